// File: doc/BRIEF.md
# Relocatable Exception Vector Fetch Unit

This unit maps an exception number to the address of its entry in a table of 32-bit words and reads that entry through a single word-read memory port. Software sets where the table sits through a writable offset register. One bit of that register selects the code region or the SRAM region. The other writable bits give the distance from the bottom of the chosen region.

Coming out of reset, the unit runs a fixed boot sequence. It reads table word 0 and presents it as the initial stack pointer. It then reads word 1 and presents it as the reset handler address. Only after both reads does it accept exception requests. Each request is accepted with a valid/ready handshake. Only one memory read is ever in flight. A request for an entry that holds no handler raises an error pulse and does not reach memory.

The table length in words is `NUM_IRQ + 16`. The table base is aligned to that length rounded up to a power of two, with a minimum of 32 words. Offset bits below that alignment cannot be written.

Top module: `vec_fetch_unit`

## Requirements
- R1: The fetch address is the region base plus the offset field plus 4 times the exception number. The region base is 0x0000_0000 when register bit 29 is 0 and 0x2000_0000 when it is 1, and the offset field is register bits [28:0] with the bits below the alignment held at zero.
- R2: After reset, the unit reads base+0x0 and shows the data on `sp_init` with `sp_valid` held high. It then reads base+0x4 and shows that data on `handler_addr` with a one-cycle `handler_valid` pulse.
- R3: `exc_ready` stays low from reset until the reset handler word has been returned.
- R4: These exception numbers map to these byte offsets: 2→0x08, 3→0x0C, 4→0x10, 5→0x14, 6→0x18, 11→0x2C, 12→0x30, 14→0x38, 15→0x3C. External interrupt n is exception number 16+n at offset 0x40+4·n.
- R5: The offset register resets to 0. Only bit 29 and bits [28:A] are writable, where 2^A is the alignment in bytes, and every other bit reads back 0. The alignment is max(32, NUM_IRQ+16 rounded up to a power of two) words. With the default NUM_IRQ=32 this gives A=8.
- R6: Exception numbers 0, 7, 8, 9, 10 and 13, and every number at or above NUM_IRQ+16, are rejected. A rejected request is still accepted, gives a one-cycle `exc_err` pulse in the cycle after acceptance, and issues no memory read.
- R7: At most one read is outstanding. `exc_ready` is low while `mem_req` is high, and `mem_addr` holds steady until `mem_valid` arrives.
- R8: In the cycle after `mem_valid` for an exception fetch, `handler_valid` pulses for one cycle and `handler_addr` equals the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the offset register |
| reg_wr_data | input | 32 | Offset register write value |
| reg_rd_data | output | 32 | Offset register read value |
| exc_valid | input | 1 | Exception request valid |
| exc_num | input | 8 | Exception number |
| exc_ready | output | 1 | Unit can accept a request |
| exc_err | output | 1 | Pulse: rejected exception number |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| handler_valid | output | 1 | Pulse: handler address is valid |
| handler_addr | output | 32 | Fetched handler address |
| sp_valid | output | 1 | Initial stack pointer has been loaded |
| sp_init | output | 32 | Initial stack pointer value |

## Verification
The bench walks one table of exception numbers twice: once with the table in the code region at base zero, and once after relocating it into SRAM with junk in the unwritable low offset bits. A design that does not mask those bits, or that ignores the region bit, sends reads to the wrong address. The rejected entries are included in the table: the reserved numbers around 0x1C–0x28 and 0x34, entry 0, and the numbers just past the table end. A design that lets any of them through issues a memory read instead of an error pulse. The boot sequence is checked for its order and for the point at which `exc_ready` rises. A design that swaps the two boot words, or opens the request port early, shows the wrong value on `sp_init` or a premature ready.

// File: rtl/vecfetch_pkg.sv
package vecfetch_pkg;

    localparam logic [31:0] CODE_BASE  = 32'h0000_0000;
    localparam logic [31:0] SRAM_BASE  = 32'h2000_0000;
    localparam int          REGION_BIT = 29;

    typedef enum logic [1:0] {
        ST_BOOT_SP,
        ST_BOOT_PC,
        ST_IDLE,
        ST_FETCH
    } fetch_state_e;

    typedef struct packed {
        logic        region_sram;
        logic [28:0] offset;
    } tbl_base_t;

    function automatic int table_words(input int n_irq);
        return n_irq + 16;
    endfunction

    // log2 of the required table alignment in bytes
    function automatic int align_lsb(input int n_irq);
        for (int i = 5; i <= 8; i++) begin
            if ((1 << i) >= table_words(n_irq)) return i + 2;
        end
        return 10;
    endfunction

    function automatic logic is_reserved(input logic [7:0] num);
        return (num == 8'd0) || (num >= 8'd7 && num <= 8'd10) || (num == 8'd13);
    endfunction

endpackage

// File: rtl/vf_offset_reg.sv
module vf_offset_reg
    import vecfetch_pkg::*;
#(
    parameter int ALIGN_LSB = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output tbl_base_t   base
);
    localparam logic [31:0] OFF_MASK = (32'h1FFF_FFFF >> ALIGN_LSB) << ALIGN_LSB;
    localparam logic [31:0] WR_MASK  = OFF_MASK | (32'h1 << REGION_BIT);

    logic [31:0] reg_q;

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else if (wr_en) reg_q <= wr_data & WR_MASK;
    end

    assign rd_data          = reg_q;
    assign base.region_sram = reg_q[REGION_BIT];
    assign base.offset      = reg_q[28:0];
endmodule

// File: rtl/vf_addr_gen.sv
module vf_addr_gen
    import vecfetch_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  tbl_base_t   base,
    input  logic [7:0]  exc_num,
    output logic [31:0] tbl_base_addr,
    output logic [31:0] entry_addr,
    output logic        entry_bad
);
    localparam int TBL_WORDS = table_words(NUM_IRQ);

    assign tbl_base_addr = (base.region_sram ? SRAM_BASE : CODE_BASE) + {3'b000, base.offset};
    assign entry_addr    = tbl_base_addr + {22'd0, exc_num, 2'b00};
    assign entry_bad     = is_reserved(exc_num) || ({24'd0, exc_num} >= 32'(TBL_WORDS));
endmodule

// File: rtl/vf_fetch_ctrl.sv
module vf_fetch_ctrl
    import vecfetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] tbl_base_addr,
    input  logic [31:0] entry_addr,
    input  logic        entry_bad,
    input  logic        exc_valid,
    output logic        exc_ready,
    output logic        exc_err,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_rdata,
    output logic        handler_valid,
    output logic [31:0] handler_addr,
    output logic        sp_valid,
    output logic [31:0] sp_init
);
    fetch_state_e state_q;
    logic [31:0]  addr_q;
    logic         accept;

    assign accept    = (state_q == ST_IDLE) && exc_valid;
    assign exc_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q != ST_IDLE);
    assign mem_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_BOOT_SP;
            addr_q        <= '0;
            exc_err       <= 1'b0;
            handler_valid <= 1'b0;
            handler_addr  <= '0;
            sp_valid      <= 1'b0;
            sp_init       <= '0;
        end else begin
            exc_err       <= 1'b0;
            handler_valid <= 1'b0;
            unique case (state_q)
                ST_BOOT_SP: if (mem_valid) begin
                    sp_init  <= mem_rdata;
                    sp_valid <= 1'b1;
                    addr_q   <= tbl_base_addr + 32'd4;
                    state_q  <= ST_BOOT_PC;
                end
                ST_BOOT_PC, ST_FETCH: if (mem_valid) begin
                    handler_addr  <= mem_rdata;
                    handler_valid <= 1'b1;
                    state_q       <= ST_IDLE;
                end
                ST_IDLE: if (accept) begin
                    if (entry_bad) begin
                        exc_err <= 1'b1;
                    end else begin
                        addr_q  <= entry_addr;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vec_fetch_unit.sv
module vec_fetch_unit
    import vecfetch_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        exc_valid,
    input  logic [7:0]  exc_num,
    output logic        exc_ready,
    output logic        exc_err,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_rdata,
    output logic        handler_valid,
    output logic [31:0] handler_addr,
    output logic        sp_valid,
    output logic [31:0] sp_init
);
    localparam int ALIGN_LSB = align_lsb(NUM_IRQ);

    tbl_base_t   base;
    logic [31:0] tbl_base_addr;
    logic [31:0] entry_addr;
    logic        entry_bad;

    vf_offset_reg #(.ALIGN_LSB(ALIGN_LSB)) u_offset_reg (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .rd_data(reg_rd_data), .base(base)
    );

    vf_addr_gen #(.NUM_IRQ(NUM_IRQ)) u_addr_gen (
        .base(base), .exc_num(exc_num), .tbl_base_addr(tbl_base_addr),
        .entry_addr(entry_addr), .entry_bad(entry_bad)
    );

    vf_fetch_ctrl u_fetch_ctrl (
        .clk(clk), .rst(rst), .tbl_base_addr(tbl_base_addr),
        .entry_addr(entry_addr), .entry_bad(entry_bad),
        .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_err(exc_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .handler_valid(handler_valid),
        .handler_addr(handler_addr), .sp_valid(sp_valid), .sp_init(sp_init)
    );
endmodule

// File: rtl/vf_checker.sv
module vf_checker
    import vecfetch_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] reg_rd_data,
    input logic        exc_ready,
    input logic        exc_err,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        handler_valid,
    input logic        sp_valid
);
    localparam int          LSB      = align_lsb(NUM_IRQ);
    localparam logic [31:0] RO_MASK  = ~(((32'h1FFF_FFFF >> LSB) << LSB) | 32'h2000_0000);

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !exc_ready);                                              // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));          // R7
    AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (rst)
        exc_err |-> !mem_req);                                                // R6
    AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data & RO_MASK) == 32'd0);                                    // R5
    AST_SP_BEFORE_HANDLER: assert property (@(posedge clk) disable iff (rst)
        handler_valid |-> sp_valid);                                          // R2
    AST_SP_STICKY: assert property (@(posedge clk) disable iff (rst)
        sp_valid |=> sp_valid);                                               // R2
    AST_READY_AFTER_BOOT: assert property (@(posedge clk) disable iff (rst)
        !sp_valid |-> !exc_ready);                                            // R3
    AST_HANDLER_FROM_MEM: assert property (@(posedge clk) disable iff (rst)
        $rose(handler_valid) |-> $past(mem_valid));                           // R8
endmodule

bind vec_fetch_unit vf_checker #(.NUM_IRQ(NUM_IRQ)) u_vf_checker (
    .clk(clk), .rst(rst), .reg_rd_data(reg_rd_data), .exc_ready(exc_ready),
    .exc_err(exc_err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .handler_valid(handler_valid), .sp_valid(sp_valid)
);

// File: tb/test_vec_fetch_unit.sv
`timescale 1ns/1ps
module test_vec_fetch_unit;
    localparam int NUM_IRQ = 32;
    localparam int LAT     = 2;
    localparam int NV      = 16;
    // 48-word table -> 64-word (256-byte) alignment -> writable offset bits [28:8] plus bit 29
    localparam logic [31:0] WR_MASK = 32'h3FFF_FF00;

    localparam logic [7:0] T_NUM [NV] = '{8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd11, 8'd12, 8'd14,
                                          8'd15, 8'd16, 8'd47, 8'd0, 8'd7, 8'd13, 8'd48, 8'd255};
    localparam bit         T_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
    localparam logic [7:0] T_OFF [NV] = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h2C, 8'h30, 8'h38,
                                          8'h3C, 8'h40, 8'hBC, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr_en = 0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        exc_valid = 0;
    logic [7:0]  exc_num = '0;
    logic        exc_ready, exc_err, mem_req, handler_valid, sp_valid;
    logic [31:0] mem_addr, handler_addr, sp_init;
    logic        mem_valid = 0;
    logic [31:0] mem_rdata = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          lat_cnt = 0;

    always #2.5 clk = ~clk;

    vec_fetch_unit #(.NUM_IRQ(NUM_IRQ)) i_vec_fetch_unit (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    // memory model: answers a held request after LAT cycles
    always @(posedge clk) begin
        if (rst || mem_valid) begin
            mem_valid <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_req) begin
            if (lat_cnt == LAT - 1) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                lat_cnt   <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_handler(input string req, input logic [31:0] exp);
        int t = 0;
        while (!handler_valid && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(req, {31'd0, handler_valid}, 32'd1);
        chk(req, handler_addr, exp);
    endtask

    task automatic do_exc(input logic [7:0] num, input bit err, input logic [31:0] exp_addr);
        @(negedge clk);
        while (!exc_ready) @(negedge clk);
        exc_valid = 1;
        exc_num   = num;
        @(negedge clk);
        exc_valid = 0;
        if (err) begin
            chk("R6 err pulse", {31'd0, exc_err}, 32'd1);
            chk("R6 no read", {31'd0, mem_req}, 32'd0);
            @(negedge clk);
            chk("R6 err one cycle", {31'd0, exc_err}, 32'd0);
        end else begin
            chk("R1 R4 fetch addr", mem_addr, exp_addr);
            chk("R7 ready low while busy", {31'd0, exc_ready}, 32'd0);
            wait_handler("R8 handler data", mem_word(exp_addr));
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic run_table(input logic [31:0] base);
        for (int i = 0; i < NV; i++) begin
            do_exc(T_NUM[i], T_ERR[i], base + {24'd0, T_OFF[i]});
        end
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk("R3 ready in reset", {31'd0, exc_ready}, 32'd0);
        chk("R5 reg reset", reg_rd_data, 32'd0);
        chk("R2 first read addr", mem_addr, 32'd0);
        chk("R2 sp invalid in reset", {31'd0, sp_valid}, 32'd0);
        rst = 0;

        t = 0;
        while (!sp_valid && t < 50) begin
            @(negedge clk);
            t++;
            if (!sp_valid) chk("R3 ready before boot", {31'd0, exc_ready}, 32'd0);
        end
        chk("R2 sp value", sp_init, mem_word(32'd0));
        chk("R2 second read addr", mem_addr, 32'd4);
        chk("R3 ready during boot", {31'd0, exc_ready}, 32'd0);
        wait_handler("R2 reset handler", mem_word(32'd4));
        chk("R3 ready after boot", {31'd0, exc_ready}, 32'd1);

        run_table(32'h0000_0000);

        write_reg(32'hFFFF_FFFF);
        chk("R5 writable mask", reg_rd_data, WR_MASK);
        write_reg(32'h2000_01FF);
        chk("R5 low bits dropped", reg_rd_data, 32'h2000_0100);
        run_table(32'h2000_0100);

        write_reg(32'h0000_0A80);
        chk("R5 code region readback", reg_rd_data, 32'h0000_0A00);
        do_exc(8'd16, 0, 32'h0000_0A40);
        do_exc(8'd3, 0, 32'h0000_0A0C);

        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R5 reg cleared by reset", reg_rd_data, 32'd0);
        chk("R2 reboot reads base", mem_addr, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule